// File: doc/BRIEF.md
# Segmented SRAM Address Latch Controller

This block lets a small microcontroller with only an 8-bit data port drive the full 19-bit address of a byte-wide static RAM of up to 512 KB, plus a handful of chip enables. The host presents a 3-bit select code and a data byte, pulls its active-low strobe low, then releases it. On the release the byte lands in the register named by the select code. Three codes cover the address, one segment each: the low byte, the middle byte, and the top three bits. A fourth code writes an enable register that drives the RAM select and four auxiliary enables.

Each address segment holds its value until it is written again, so the address bus also works as a bank of general-purpose latched outputs when no RAM is fitted. The strobe is asynchronous to the system clock. It passes through a two-flop synchronizer, and its rising edge is detected in the clock domain. The enable register stores a 1 for "asserted" in every bit, and each output pin applies its own polarity. Three auxiliary enables are active-low. The fourth is active-high, which suits a display enable or the latch enable of an external latch.

Top module: `sram_seg_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, addr_out is zero, ram_sel_n is 1, aux_en_n is 3'b111 and aux_en_hi is 0. Reset takes effect without waiting for a clock edge.
- R2: A register is written only when host_cs_n goes from 0 to 1. Holding host_cs_n low writes nothing. The outputs change on the third rising clock edge after host_cs_n rises, and stay unchanged at the second. host_sel and host_data must be held stable until that third edge.
- R3: Select code 3'b000 loads host_data[7:0] into addr_out[7:0].
- R4: Select code 3'b001 loads host_data[7:0] into addr_out[15:8].
- R5: Select code 3'b010 loads host_data[2:0] into addr_out[18:16]. host_data[7:3] is ignored.
- R6: Select code 3'b011 loads the enable register. Bit 0 asserts the RAM select, so ram_sel_n = ~bit0. Bits 1, 2 and 3 assert aux_en_n[0], aux_en_n[1] and aux_en_n[2], each output being the inverse of its bit. Bit 4 drives aux_en_hi directly. host_data[7:5] is ignored.
- R7: Select codes 3'b100 to 3'b111 change no address bit and no enable output.
- R8: Writing one address segment leaves the other segments and the enable outputs unchanged. Writing the enable register leaves the address unchanged.
- R9: Between writes, every output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_data | input | 8 | Data byte from the host |
| host_sel | input | 3 | Select code naming the target register |
| host_cs_n | input | 1 | Active-low host strobe; its rising edge triggers the write |
| addr_out | output | 19 | Latched SRAM address or general-purpose outputs |
| ram_sel_n | output | 1 | Active-low SRAM chip select |
| aux_en_n | output | 3 | Active-low auxiliary enables 1 to 3 |
| aux_en_hi | output | 1 | Active-high auxiliary enable 4 |

## Verification
The assertions check four things on every clock. Each internal write pulse must follow a real low-to-high transition of host_cs_n. Each segment and the enable register must take exactly the byte that was on the bus when the pulse fired. Unused codes and writes to other registers must leave everything else untouched. Nothing may move in a cycle without a write. Some behaviour can only be shown by the bench's scenarios: the exact three-edge latency seen from the pins, the absence of any write while the strobe is held low, the outputs during an asynchronous mid-run reset, and whole sequences of mixed writes reaching a known address and enable pattern.

// File: rtl/sram_seg_pkg.sv
package sram_seg_pkg;

  // Width of the host select field
  localparam int SEL_W = 3;

  typedef logic [SEL_W-1:0] sel_t;

  // Select codes whose order is decoded by the address bank
  typedef enum logic [SEL_W-1:0] {
    CODE_ADDR_LO  = 3'd0,
    CODE_ADDR_MID = 3'd1,
    CODE_ADDR_TOP = 3'd2,
    CODE_ENABLES  = 3'd3
  } seg_code_e;

  // Number of data-wide segments needed to cover an address
  function automatic int seg_count(input int addr_w, input int data_w);
    return (addr_w + data_w - 1) / data_w;
  endfunction

endpackage

// File: rtl/seg_reset_sync.sv
module seg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/seg_strobe_sync.sv
module seg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_async,
  output logic rise_pulse
);

  // Chain idles high so reset release cannot fake an edge
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], cs_n_async};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_pulse = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/seg_addr_bank.sv
module seg_addr_bank
  import sram_seg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  sel_t              sel,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] addr
);

  localparam int NSEG = seg_count(ADDR_W, DATA_W);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = g * DATA_W;
    localparam int W  = ((ADDR_W - LO) < DATA_W) ? (ADDR_W - LO) : DATA_W;

    logic         seg_we;
    logic [W-1:0] seg_q;
    logic [W-1:0] seg_d;

    // Clock enable for this segment only
    assign seg_we = wr_pulse && (sel == sel_t'(g));

    always_comb begin
      seg_d = seg_q;
      if (seg_we) begin
        seg_d = data[W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q <= '0;
      end else begin
        seg_q <= seg_d;
      end
    end

    assign addr[LO +: W] = seg_q;
  end

endmodule

// File: rtl/seg_enable_reg.sv
module seg_enable_reg #(
  parameter  int N_AUX_LOW = 3,
  localparam int EN_W      = N_AUX_LOW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [EN_W-1:0]      data,
  output logic                 ram_sel_n,
  output logic [N_AUX_LOW-1:0] aux_en_n,
  output logic                 aux_en_hi
);

  // Stored sense: 1 means asserted, polarity applied at the pins
  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (load) begin
      en_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign ram_sel_n = ~en_q[0];
  assign aux_en_n  = ~en_q[N_AUX_LOW:1];
  assign aux_en_hi = en_q[N_AUX_LOW+1];

endmodule

// File: rtl/sram_seg_ctrl.sv
module sram_seg_ctrl
  import sram_seg_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int N_AUX_LOW   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    host_data,
  input  logic [SEL_W-1:0]     host_sel,
  input  logic                 host_cs_n,
  output logic [ADDR_W-1:0]    addr_out,
  output logic                 ram_sel_n,
  output logic [N_AUX_LOW-1:0] aux_en_n,
  output logic                 aux_en_hi
);

  localparam int NSEG = seg_count(ADDR_W, DATA_W);
  localparam int EN_W = N_AUX_LOW + 2;

  logic rst_sync_n;
  logic wr_pulse;
  logic en_load;

  seg_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_out (rst_sync_n)
  );

  seg_strobe_sync #(.STAGES(SYNC_STAGES)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n_async (host_cs_n),
    .rise_pulse (wr_pulse)
  );

  seg_addr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_pulse (wr_pulse),
    .sel      (host_sel),
    .data     (host_data),
    .addr     (addr_out)
  );

  // The code after the last address segment selects the enables
  assign en_load = wr_pulse && (host_sel == sel_t'(NSEG));

  seg_enable_reg #(.N_AUX_LOW(N_AUX_LOW)) u_en (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (en_load),
    .data      (host_data[EN_W-1:0]),
    .ram_sel_n (ram_sel_n),
    .aux_en_n  (aux_en_n),
    .aux_en_hi (aux_en_hi)
  );

endmodule

// File: rtl/sram_seg_ctrl_chk.sv
module sram_seg_ctrl_chk
  import sram_seg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              wr_pulse,
  input logic              host_cs_n,
  input logic [2:0]        host_sel,
  input logic [DATA_W-1:0] host_data,
  input logic [ADDR_W-1:0] addr_out,
  input logic              ram_sel_n,
  input logic [2:0]        aux_en_n,
  input logic              aux_en_hi
);

  logic [4:0] pins_en;
  assign pins_en = {ram_sel_n, aux_en_n, aux_en_hi};

  // R2: a write pulse follows a real low-to-high strobe transition
  p_strobe_edge_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_pulse |-> ($past(host_cs_n, 2) && !$past(host_cs_n, 3)));

  // R3: low byte takes the bus
  p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel == CODE_ADDR_LO) |=>
      addr_out[DATA_W-1:0] == $past(host_data));

  // R4: middle byte takes the bus
  p_load_mid_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel == CODE_ADDR_MID) |=>
      addr_out[2*DATA_W-1:DATA_W] == $past(host_data));

  // R5: top bits take only the low data bits
  p_load_top_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel == CODE_ADDR_TOP) |=>
      addr_out[ADDR_W-1:2*DATA_W] == $past(host_data[ADDR_W-2*DATA_W-1:0]));

  // R6: enable pins follow the written sense with their own polarity
  p_load_en_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel == CODE_ENABLES) |=>
      (ram_sel_n == !$past(host_data[0])) &&
      (aux_en_n == ~$past(host_data[3:1])) &&
      (aux_en_hi == $past(host_data[4])));

  // R7: unused codes touch nothing
  p_unused_code_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel[2]) |=> ($stable(addr_out) && $stable(pins_en)));

  // R8: an address write leaves the enables alone
  p_isolate_en_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel != CODE_ENABLES) |=> $stable(pins_en));

  // R8: an enable write leaves the address alone
  p_isolate_addr_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_pulse && host_sel == CODE_ENABLES) |=> $stable(addr_out));

  // R9: nothing moves without a write
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_pulse |=> ($stable(addr_out) && $stable(pins_en)));

endmodule

bind sram_seg_ctrl sram_seg_ctrl_chk #(.ADDR_W(19), .DATA_W(8)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .wr_pulse  (wr_pulse),
  .host_cs_n (host_cs_n),
  .host_sel  (host_sel),
  .host_data (host_data),
  .addr_out  (addr_out),
  .ram_sel_n (ram_sel_n),
  .aux_en_n  (aux_en_n),
  .aux_en_hi (aux_en_hi)
);

// File: tb/sim_sram_seg_ctrl.sv
module sim_sram_seg_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_LIMIT   = 20000;
  localparam int  NVEC       = 11;
  localparam logic [23:0] IDLE = {19'h00000, 5'b11110};

  // Entry: {sel[3], data[8], expected addr[19], expected {ram_sel_n, aux_en_n[3], aux_en_hi}}
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 8'hA5, 19'h000A5, 5'b11110},
    {3'd1, 8'h3C, 19'h03CA5, 5'b11110},
    {3'd2, 8'hFF, 19'h73CA5, 5'b11110},
    {3'd3, 8'h01, 19'h73CA5, 5'b01110},
    {3'd3, 8'h1E, 19'h73CA5, 5'b10001},
    {3'd4, 8'h00, 19'h73CA5, 5'b10001},
    {3'd7, 8'hFF, 19'h73CA5, 5'b10001},
    {3'd2, 8'hFA, 19'h23CA5, 5'b10001},
    {3'd3, 8'hE4, 19'h23CA5, 5'b11010},
    {3'd0, 8'h00, 19'h23C00, 5'b11010},
    {3'd5, 8'h55, 19'h23C00, 5'b11010}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  host_data;
  logic [2:0]  host_sel;
  logic        host_cs_n;
  logic [18:0] addr_out;
  logic        ram_sel_n;
  logic [2:0]  aux_en_n;
  logic        aux_en_hi;

  int checks;
  int failures;
  int cycles;
  bit done;

  sram_seg_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_data (host_data),
    .host_sel  (host_sel),
    .host_cs_n (host_cs_n),
    .addr_out  (addr_out),
    .ram_sel_n (ram_sel_n),
    .aux_en_n  (aux_en_n),
    .aux_en_hi (aux_en_hi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [23:0] obs();
    return {addr_out, ram_sel_n, aux_en_n, aux_en_hi};
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R6";
      5: return "R7";
      6: return "R7";
      7: return "R5";
      8: return "R6";
      9: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel  = s;
    host_data = d;
    host_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    host_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !done) begin
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    checks    = 0;
    failures  = 0;
    cycles    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    host_data = 8'h00;
    host_sel  = 3'd0;
    host_cs_n = 1'b1;

    // R1: state while in reset and after release
    repeat (4) @(negedge clk);
    check("R1 in reset", obs(), IDLE);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", obs(), IDLE);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][34:32], VEC[i][31:24]);
      check(req_of(i), obs(), VEC[i][23:0]);
    end

    // R9: hold over idle cycles
    repeat (20) @(negedge clk);
    check("R9 idle hold", obs(), {19'h23C00, 5'b11010});

    // R2: strobe held low writes nothing
    host_sel  = 3'd0;
    host_data = 8'h77;
    host_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 held low", obs(), {19'h23C00, 5'b11010});

    // R2: exact latency after the rising edge
    host_cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 second edge", obs(), {19'h23C00, 5'b11010});
    @(negedge clk);
    check("R2 third edge", obs(), {19'h23C77, 5'b11010});

    // R5/R8: top segment at its widest value
    do_write(3'd2, 8'h07);
    check("R5 top max", obs(), {19'h73C77, 5'b11010});

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", obs(), IDLE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after mid-run release", obs(), IDLE);

    // R6: all enables asserted after reset
    do_write(3'd3, 8'h1F);
    check("R6 all asserted", obs(), {19'h00000, 5'b00001});

    finish_run();
  end

endmodule